// File: doc/BRIEF.md
# Dual Multiply-Add Datapath Unit

This unit carries out one step of a sum-of-products in a single clock cycle. It takes two 32-bit signed data operands and two 16-bit signed coefficients. It forms the two 32x16 products and adds them at 48-bit width. An arithmetic right shift then scales the sum by a 5-bit amount, and the low 32 bits of the shifted value are kept. A core issues one of these operations per cycle while it works through a filter tap loop or a transform butterfly. The shift brings a fixed-point result back to the working Q format.

The arithmetic is purely combinational. A parameter selects whether a result register follows it. With the register fitted (the default), the result and a valid flag appear one clock after the operands are presented. Without it, the result and the flag follow the inputs in the same cycle.

Top module: `dual_mac_unit`

## Requirements
- R1: Each lane multiplies its 32-bit two's-complement operand by its 16-bit two's-complement coefficient, and the product is sign-extended to 48 bits.
- R2: The two 48-bit products are added modulo 2^48. When both products are at their largest positive value (-2^31 times -2^15 in both lanes) the sum wraps to -2^47.
- R3: The 48-bit sum is shifted right arithmetically by `shift_amt`, an unsigned value from 0 to 31. The sign bit fills the vacated positions, so negative values round toward minus infinity.
- R4: `result` is bits 31..0 of the shifted 48-bit value. Any higher bits are discarded without saturation.
- R5: With the output register fitted, `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R6: The result register loads only in cycles with `in_valid` high. Operands presented with `in_valid` low leave `result` unchanged.
- R7: A synchronous active-high `rst` clears `out_valid` and `result` to zero at the next rising edge, and this takes priority over `in_valid`.
- R8: A new operation can start every cycle. When `in_valid` is held high, each cycle's operands produce their own result on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| op_x0 | input | 32 | Lane 0 data operand, signed |
| coef_k0 | input | 16 | Lane 0 coefficient, signed |
| op_x1 | input | 32 | Lane 1 data operand, signed |
| coef_k1 | input | 16 | Lane 1 coefficient, signed |
| shift_amt | input | 5 | Arithmetic right shift distance, 0..31 |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Low 32 bits of the shifted sum |

## Verification
The hardest condition to reach is the 48-bit wrap of the sum. It occurs only when both lanes hold the most negative data operand and the most negative coefficient together, and random operands essentially never produce it. The vector table therefore places that pair in both lanes. It applies the pair once with no shift, where the low word reads zero, and once with the largest shift, where the wrapped sign must spread into the upper half of the result. Further vectors target other cases:
- products that exceed 32 bits, to check truncation;
- opposing products that cancel;
- odd negative sums, to check floor rounding.

A random phase then draws operands from a pool of extreme and arbitrary values and compares each result with a wide-integer reference.

// File: rtl/dmu_pkg.sv
package dmu_pkg;

    localparam int OP_W   = 32;
    localparam int CF_W   = 16;
    localparam int ACC_W  = 48;
    localparam int SH_W   = 5;
    localparam int RES_W  = 32;
    localparam int NLANE  = 2;

    typedef struct packed {
        logic signed [OP_W-1:0] data;
        logic signed [CF_W-1:0] coef;
    } lane_t;

    typedef struct packed {
        logic                    vld;
        logic [RES_W-1:0]        val;
    } res_t;

    function automatic logic signed [ACC_W-1:0] lane_product(input lane_t ln);
        logic signed [OP_W+CF_W-1:0] wide;
        wide = (OP_W+CF_W)'(ln.data) * (OP_W+CF_W)'(ln.coef);
        return ACC_W'(wide);
    endfunction

endpackage

// File: rtl/dmu_lane_mul.sv
module dmu_lane_mul
    import dmu_pkg::*;
(
    input  lane_t                   lane,
    output logic signed [ACC_W-1:0] prod
);

    always_comb begin
        prod = lane_product(lane);
    end

    // A nonzero product of a negative and a positive operand is negative
    always_comb begin
        if (lane.data != '0 && lane.coef != '0)
            AST_PROD_SIGN: assert (prod[ACC_W-1] == (lane.data[OP_W-1] ^ lane.coef[CF_W-1])); // R1
    end

endmodule

// File: rtl/dmu_sum.sv
module dmu_sum
    import dmu_pkg::*;
#(
    parameter int N = NLANE
) (
    input  logic signed [ACC_W-1:0] terms [N],
    output logic signed [ACC_W-1:0] total
);

    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++)
            total = total + terms[i];
    end

    // Zero products give a zero sum; anything else is modular addition
    always_comb begin
        if (terms[0] == '0)
            AST_SUM_IDENT: assert (total == terms[N-1] || N > 2); // R2
    end

endmodule

// File: rtl/dmu_ashift.sv
module dmu_ashift
    import dmu_pkg::*;
(
    input  logic signed [ACC_W-1:0] din,
    input  logic [SH_W-1:0]         amt,
    output logic signed [ACC_W-1:0] dout
);

    logic signed [ACC_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    // Logarithmic shifter: stage i moves by 2**i when its amount bit is set
    generate
        for (genvar i = 0; i < SH_W; i++) begin : g_stage
            localparam int DIST = 1 << i;
            always_comb begin
                if (amt[i])
                    stage[i+1] = {{DIST{stage[i][ACC_W-1]}}, stage[i][ACC_W-1:DIST]};
                else
                    stage[i+1] = stage[i];
            end
        end
    endgenerate

    assign dout = stage[SH_W];

    always_comb begin
        AST_SHIFT_SIGN: assert (dout[ACC_W-1] == din[ACC_W-1]); // R3
    end

endmodule

// File: rtl/dmu_out_stage.sv
module dmu_out_stage
    import dmu_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  res_t nxt,
    output res_t cur
);

    generate
        if (REGISTERED) begin : g_reg
            res_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q.vld <= nxt.vld;
                    if (nxt.vld)
                        q.val <= nxt.val;
                end
            end
            assign cur = q;

            AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
                nxt.vld |=> cur.vld); // R5
            AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
                !nxt.vld |=> !cur.vld); // R5
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
                !nxt.vld |=> $stable(cur.val)); // R6
            AST_RST_CLEAR: assert property (@(posedge clk)
                rst |=> (cur.vld == 1'b0 && cur.val == '0)); // R7
        end else begin : g_pass
            assign cur = nxt;
        end
    endgenerate

endmodule

// File: rtl/dual_mac_unit.sv
module dual_mac_unit
    import dmu_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op_x0,
    input  logic [CF_W-1:0]  coef_k0,
    input  logic [OP_W-1:0]  op_x1,
    input  logic [CF_W-1:0]  coef_k1,
    input  logic [SH_W-1:0]  shift_amt,
    output logic             out_valid,
    output logic [RES_W-1:0] result
);

    lane_t                   lanes [NLANE];
    logic signed [ACC_W-1:0] prods [NLANE];
    logic signed [ACC_W-1:0] acc_sum;
    logic signed [ACC_W-1:0] scaled;
    res_t                    nxt_res;
    res_t                    cur_res;

    assign lanes[0] = '{data: op_x0, coef: coef_k0};
    assign lanes[1] = '{data: op_x1, coef: coef_k1};

    generate
        for (genvar l = 0; l < NLANE; l++) begin : g_lane
            dmu_lane_mul u_mul (
                .lane (lanes[l]),
                .prod (prods[l])
            );
        end
    endgenerate

    dmu_sum #(.N(NLANE)) u_sum (
        .terms (prods),
        .total (acc_sum)
    );

    dmu_ashift u_shift (
        .din  (acc_sum),
        .amt  (shift_amt),
        .dout (scaled)
    );

    assign nxt_res.vld = in_valid;
    assign nxt_res.val = scaled[RES_W-1:0];

    dmu_out_stage #(.REGISTERED(OUT_REG)) u_out (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_res),
        .cur (cur_res)
    );

    assign out_valid = cur_res.vld;
    assign result    = cur_res.val;

endmodule

// File: tb/dual_mac_unit_bench.sv
`timescale 1ns/1ps
module dual_mac_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_x0, op_x1;
    logic [15:0] coef_k0, coef_k1;
    logic [4:0]  shift_amt;
    logic        out_valid;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_mac_unit u_dual_mac_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_x0(op_x0), .coef_k0(coef_k0), .op_x1(op_x1), .coef_k1(coef_k1),
        .shift_amt(shift_amt), .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [31:0] x0;
        logic [15:0] k0;
        logic [31:0] x1;
        logic [15:0] k1;
        logic [4:0]  sh;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{32'h00000003, 16'h0004, 32'h00000005, 16'h0006, 5'd1,  32'h00000015},
        '{32'hFFFFFFFF, 16'h0001, 32'h00000000, 16'h0000, 5'd0,  32'hFFFFFFFF},
        '{32'h80000000, 16'h8000, 32'h80000000, 16'h8000, 5'd0,  32'h00000000},
        '{32'h80000000, 16'h8000, 32'h80000000, 16'h8000, 5'd31, 32'hFFFF0000},
        '{32'h7FFFFFFF, 16'h7FFF, 32'h00000000, 16'h0000, 5'd0,  32'h7FFF8001},
        '{32'h7FFFFFFF, 16'h7FFF, 32'h00000000, 16'h0000, 5'd16, 32'h3FFF7FFF},
        '{32'h80000000, 16'h7FFF, 32'h00000000, 16'h0000, 5'd31, 32'hFFFF8001},
        '{32'h00000064, 16'h0007, 32'hFFFFFF9C, 16'h0007, 5'd3,  32'h00000000},
        '{32'hFFFFFFFD, 16'h0001, 32'h00000000, 16'h0000, 5'd1,  32'hFFFFFFFE},
        '{32'h00010000, 16'h1000, 32'h00100000, 16'h4000, 5'd0,  32'h10000000},
        '{32'h00010000, 16'h1000, 32'h00100000, 16'h4000, 5'd4,  32'h41000000}
    };

    function automatic logic [31:0] ref_model(input logic [31:0] x0, input logic [15:0] k0,
                                               input logic [31:0] x1, input logic [15:0] k1,
                                               input logic [4:0] sh);
        longint p0, p1, s;
        logic signed [47:0] s48;
        logic signed [47:0] sh48;
        p0   = longint'($signed(x0)) * longint'($signed(k0));
        p1   = longint'($signed(x1)) * longint'($signed(k1));
        s    = p0 + p1;
        s48  = s[47:0];
        sh48 = s48 >>> sh;
        return sh48[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] x0, input logic [15:0] k0,
                         input logic [31:0] x1, input logic [15:0] k1, input logic [4:0] sh);
        in_valid = v; op_x0 = x0; coef_k0 = k0; op_x1 = x1; coef_k1 = k1; shift_amt = sh;
    endtask

    function automatic logic [31:0] pick32(input int sel);
        case (sel % 6)
            0: return 32'h80000000;
            1: return 32'h7FFFFFFF;
            2: return 32'hFFFFFFFF;
            3: return 32'h00000000;
            default: return $urandom;
        endcase
    endfunction

    function automatic logic [15:0] pick16(input int sel);
        case (sel % 6)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0001;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] last;
        logic [31:0] pend;
        rst = 1'b1;
        drive(1'b0, '0, '0, '0, '0, '0);
        repeat (3) @(negedge clk);
        check("R7 reset out_valid", 32'(out_valid), 32'd0);
        check("R7 reset result", result, 32'd0);
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(1'b1, VEC[i].x0, VEC[i].k0, VEC[i].x1, VEC[i].k1, VEC[i].sh);
            @(negedge clk);
            drive(1'b0, '0, '0, '0, '0, '0);
            check($sformatf("R1/R2/R3/R4 vector %0d", i), result, VEC[i].exp);
            check("R5 valid after in_valid", 32'(out_valid), 32'd1);
            @(negedge clk);
            check("R5 valid drops", 32'(out_valid), 32'd0);
        end

        // Idle operands are ignored: R6
        @(negedge clk);
        drive(1'b1, 32'h00000011, 16'h0002, 32'h00000001, 16'h0003, 5'd0);
        @(negedge clk);
        last = result;
        check("R6 load", last, 32'h00000025);
        drive(1'b0, 32'h7FFFFFFF, 16'h7FFF, 32'h7FFFFFFF, 16'h7FFF, 5'd0);
        @(negedge clk);
        check("R6 hold result", result, last);
        check("R6 hold valid", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R6 hold result later", result, last);

        // Back-to-back stream with extreme/random pool: R8
        drive(1'b1, pick32(0), pick16(0), pick32(0), pick16(0), 5'd0);
        pend = ref_model(op_x0, coef_k0, op_x1, coef_k1, shift_amt);
        for (int j = 1; j < 400; j++) begin
            @(negedge clk);
            check("R8 streamed result", result, pend);
            if (!out_valid) check("R8 streamed valid", 32'(out_valid), 32'd1);
            drive(1'b1, pick32(j), pick16(j / 6 + j), pick32($urandom), pick16($urandom),
                  5'($urandom));
            pend = ref_model(op_x0, coef_k0, op_x1, coef_k1, shift_amt);
        end
        @(negedge clk);
        check("R8 last streamed", result, pend);

        // Reset beats in_valid: R7
        drive(1'b1, 32'h00000005, 16'h0005, 32'h0, 16'h0, 5'd0);
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset priority valid", 32'(out_valid), 32'd0);
        check("R7 reset priority result", result, 32'd0);
        rst = 1'b0;
        drive(1'b0, '0, '0, '0, '0, '0);
        @(negedge clk);
        check("R5 idle after reset", 32'(out_valid), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule